// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Unit

This block sits between the load/store port of a single-issue processor and a word-wide data memory with one cycle of read latency. Each request carries an operation (plain load, plain store, load-reserved or store-conditional), a decoded write flag, a base register value, a signed immediate offset and store data. The unit forms the effective address, checks word alignment, drives the memory, and returns one response per request with read data, a conditional-store status code, or an alignment fault with its cause code.

One reservation is held: a valid bit and a word address. A load-reserved sets it. A store-conditional writes memory only while the reservation is live and names the same word. Every store-conditional consumes the reservation. A dedicated clear input drops the reservation at any time.

The controller is a three-state machine. IDLE accepts a request (transition ACCEPT). An aligned load or load-reserved moves to LOAD_WAIT (transition READ_ISSUED) to collect the memory word. Every other request moves straight to REPLY (transition DIRECT_REPLY), and LOAD_WAIT moves to REPLY (transition DATA_CAPTURED). REPLY presents the response for one cycle and returns to IDLE (transition RETIRE).

Top module: `lrsc_unit`

## Requirements
- R1: After reset the unit is ready (`req_ready` = 1), `rsp_valid` and `mem_en` are 0, and no reservation is held, so a store-conditional as the first request fails.
- R2: An aligned load-reserved (op 2) returns the current memory word in `rsp_data` and records a reservation for that word; a plain load (op 0) returns the word and records nothing.
- R3: A store-conditional (op 3) to the word held by a live reservation writes its data to memory and returns `rsp_data` = 0.
- R4: A store-conditional with no live reservation for its word returns `rsp_data` = 1 and leaves the memory word unchanged; repeating it keeps failing.
- R5: Every aligned store-conditional, passing or failing, invalidates the reservation, so a second one after a pass returns 1 and does not write.
- R6: A plain store (op 1) writes its data and creates no reservation; a following store-conditional to that word fails.
- R7: Load-reserved and store-conditional use the base value unmodified as their address; plain loads and stores use base plus the sign-extended 12-bit offset.
- R8: The reservation matches on the word address only (address bits above bit 1); a store-conditional to a different word fails and still consumes the reservation.
- R9: An address with bits [1:0] nonzero gives `rsp_err` = 1 and `rsp_cause` = 4 when the write flag is 0, or 6 when it is 1; no memory access is made and the reservation is left unchanged.
- R10: `rsv_clear` invalidates the reservation. When it coincides with an accepted load-reserved, no reservation remains; when it coincides with an accepted store-conditional, that store-conditional fails.
- R11: A request is accepted only while `req_ready` = 1; the response appears for exactly one cycle, two cycles after acceptance for an aligned load or load-reserved and one cycle after for every other request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsv_clear | input | 1 | Drops the reservation |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 2 | 0 load, 1 store, 2 load-reserved, 3 store-conditional |
| req_is_write | input | 1 | Decoded write flag, selects the fault cause |
| req_base | input | 32 | Base register value |
| req_offset | input | 12 | Signed immediate offset |
| req_wdata | input | 32 | Store data |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the read |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 32 | Load data or store-conditional status |
| rsp_err | output | 1 | Alignment fault |
| rsp_cause | output | 4 | Fault cause code |

## Verification
The clear input and a reservation operation can land in the same cycle: a clear pulse arriving with an accepted load-reserved, and one arriving with an accepted store-conditional that would otherwise pass. The bench drives the clear pulse on exactly the acceptance edge in directed cases and at random during the random phase; it judges the outcome by the store-conditional status, by the memory word, and by a probe store-conditional that must fail afterwards. Misaligned requests are mixed in at random so that a fault arriving with a live reservation must leave it intact.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LR    = 2'd2,
        OP_SC    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_LOAD_WAIT = 2'd1,
        ST_REPLY     = 2'd2
    } state_e;

    localparam int unsigned CAUSE_LOAD_MISALIGN  = 4;
    localparam int unsigned CAUSE_STORE_MISALIGN = 6;
    localparam int unsigned SC_STATUS_PASS = 0;
    localparam int unsigned SC_STATUS_FAIL = 1;

endpackage

// File: rtl/lrsc_addr_gen.sv
module lrsc_addr_gen
    import lrsc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 12,
    parameter int DATA_W  = 32,
    parameter int CAUSE_W = 4
) (
    input  op_e                 op,
    input  logic                is_write,
    input  logic [ADDR_W-1:0]   base,
    input  logic [OFF_W-1:0]    offset,
    output logic [ADDR_W-LSB_W-1:0] word_addr,
    output logic                misaligned,
    output logic [CAUSE_W-1:0]  cause
);
    localparam int LSB_W = $clog2(DATA_W / 8);

    logic [ADDR_W-1:0] eff;
    logic              atomic;

    always_comb begin
        atomic = (op == OP_LR) || (op == OP_SC);
        if (atomic)
            eff = base;
        else
            eff = base + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
        word_addr  = eff[ADDR_W-1:LSB_W];
        misaligned = |eff[LSB_W-1:0];
        cause      = is_write ? CAUSE_W'(CAUSE_STORE_MISALIGN)
                              : CAUSE_W'(CAUSE_LOAD_MISALIGN);
    end

endmodule

// File: rtl/lrsc_rsv_table.sv
module lrsc_rsv_table #(
    parameter int WA_W = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            set,
    input  logic            kill,
    input  logic [WA_W-1:0] set_addr,
    input  logic [WA_W-1:0] probe_addr,
    output logic            hit
);
    logic            valid_q;
    logic [WA_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else if (clear) begin
            valid_q <= 1'b0;
        end else if (set) begin
            valid_q <= 1'b1;
            addr_q  <= set_addr;
        end else if (kill) begin
            valid_q <= 1'b0;
        end
    end

    always_comb hit = valid_q && !clear && (addr_q == probe_addr);

    a_r10_clear_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !hit);
    a_r5_sc_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !set) |=> !valid_q);
    a_r2_lr_records: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !clear) |=> (valid_q && addr_q == $past(set_addr)));

endmodule

// File: rtl/lrsc_ctrl.sv
module lrsc_ctrl
    import lrsc_pkg::*;
#(
    parameter int WA_W    = 30,
    parameter int DATA_W  = 32,
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  op_e                op,
    input  logic               misaligned,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [WA_W-1:0]    word_addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               rsv_hit,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               req_ready,
    output logic               mem_en,
    output logic               mem_we,
    output logic [WA_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               rsv_set,
    output logic               rsv_kill,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               rsp_err,
    output logic [CAUSE_W-1:0] rsp_cause
);
    state_e             state_q, state_d;
    logic               accept;
    logic               go;
    logic [DATA_W-1:0]  data_q;
    logic               err_q;
    logic [CAUSE_W-1:0] cause_q;

    // state register and response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
            err_q   <= 1'b0;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    err_q   <= misaligned;
                    cause_q <= misaligned ? cause : '0;
                    if (!misaligned && op == OP_SC)
                        data_q <= rsv_hit ? DATA_W'(SC_STATUS_PASS) : DATA_W'(SC_STATUS_FAIL);
                    else
                        data_q <= '0;
                end
                ST_LOAD_WAIT: data_q <= mem_rdata;
                ST_REPLY: ;
                default: ;
            endcase
        end
    end

    // next state and outputs
    always_comb begin
        accept    = (state_q == ST_IDLE) && req_valid;
        go        = accept && !misaligned;
        state_d   = state_q;
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_REPLY);
        rsp_data  = data_q;
        rsp_err   = err_q;
        rsp_cause = cause_q;
        mem_addr  = word_addr;
        mem_wdata = wdata;
        mem_en    = go && (op != OP_SC || rsv_hit);
        mem_we    = go && (op == OP_STORE || (op == OP_SC && rsv_hit));
        rsv_set   = go && (op == OP_LR);
        rsv_kill  = go && (op == OP_SC);
        unique case (state_q)
            ST_IDLE: if (accept)
                state_d = (go && (op == OP_LOAD || op == OP_LR)) ? ST_LOAD_WAIT : ST_REPLY;
            ST_LOAD_WAIT: state_d = ST_REPLY;
            ST_REPLY:     state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    a_r9_no_mem_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !misaligned);
    a_r4_sc_write_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && op == OP_SC) |-> rsv_hit);
    a_r11_single_reply: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r11_wait_then_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD_WAIT) |=> rsp_valid);

endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
    import lrsc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 12,
    parameter int DATA_W  = 32,
    parameter int CAUSE_W = 4,
    localparam int LSB_W  = $clog2(DATA_W / 8),
    localparam int WA_W   = ADDR_W - LSB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rsv_clear,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_op,
    input  logic               req_is_write,
    input  logic [ADDR_W-1:0]  req_base,
    input  logic [OFF_W-1:0]   req_offset,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               mem_en,
    output logic               mem_we,
    output logic [WA_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               rsp_err,
    output logic [CAUSE_W-1:0] rsp_cause
);
    op_e                op;
    logic [WA_W-1:0]    word_addr;
    logic               misaligned;
    logic [CAUSE_W-1:0] cause;
    logic               rsv_hit;
    logic               rsv_set;
    logic               rsv_kill;

    always_comb op = op_e'(req_op);

    lrsc_addr_gen #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W)
    ) u_addr (
        .op(op), .is_write(req_is_write), .base(req_base), .offset(req_offset),
        .word_addr(word_addr), .misaligned(misaligned), .cause(cause)
    );

    lrsc_rsv_table #(.WA_W(WA_W)) u_rsv (
        .clk(clk), .rst_n(rst_n), .clear(rsv_clear), .set(rsv_set), .kill(rsv_kill),
        .set_addr(word_addr), .probe_addr(word_addr), .hit(rsv_hit)
    );

    lrsc_ctrl #(.WA_W(WA_W), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
        .misaligned(misaligned), .cause(cause), .word_addr(word_addr),
        .wdata(req_wdata), .rsv_hit(rsv_hit), .mem_rdata(mem_rdata),
        .req_ready(req_ready), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rsv_set(rsv_set),
        .rsv_kill(rsv_kill), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_err(rsp_err), .rsp_cause(rsp_cause)
    );

    a_r9_fault_reply: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && misaligned) |=> (rsp_valid && rsp_err));

endmodule

// File: tb/lrsc_unit_bench.sv
module lrsc_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rsv_clear = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic        req_is_write = 1'b0;
    logic [31:0] req_base = '0;
    logic [11:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        mem_en, mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_err;
    logic [3:0]  rsp_cause;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    lrsc_unit u_lrsc_unit (
        .clk(clk), .rst_n(rst_n), .rsv_clear(rsv_clear), .req_valid(req_valid),
        .req_ready(req_ready), .req_op(req_op), .req_is_write(req_is_write),
        .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_err(rsp_err), .rsp_cause(rsp_cause)
    );

    // bench memory, synchronous read
    logic [31:0] bmem [0:63];
    always_ff @(posedge clk) begin
        if (mem_en && mem_we) bmem[mem_addr[5:0]] <= mem_wdata;
        if (mem_en && !mem_we) mem_rdata <= bmem[mem_addr[5:0]];
    end

    // reference model
    logic [31:0] shadow [0:63];
    logic        m_valid = 1'b0;
    logic [29:0] m_word = '0;

    localparam logic [31:0] REGION = 32'h1000_0000;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] eff_addr(input logic [1:0] op, input logic [31:0] base,
                                             input logic [11:0] off);
        if (op[1]) return base;
        return base + {{20{off[11]}}, off};
    endfunction

    task automatic pulse_clear();
        @(negedge clk);
        rsv_clear = 1'b1;
        @(negedge clk);
        rsv_clear = 1'b0;
        m_valid = 1'b0;
    endtask

    // op: 0 load 1 store 2 LR 3 SC
    task automatic do_req(input string tag, input logic [1:0] op, input logic wr,
                          input logic [31:0] base, input logic [11:0] off,
                          input logic [31:0] wd, input logic clr);
        logic [31:0] ea;
        logic        mis;
        logic [5:0]  idx;
        logic [31:0] exp_data;
        logic [3:0]  exp_cause;
        int          exp_lat;
        int          lat;
        logic        hit;
        ea  = eff_addr(op, base, off);
        mis = |ea[1:0];
        idx = ea[7:2];
        exp_data = 32'd0;
        exp_cause = 4'd0;
        exp_lat = 1;
        if (mis) begin
            exp_cause = wr ? 4'd6 : 4'd4;
        end else begin
            unique case (op)
                2'd0: begin exp_data = shadow[idx]; exp_lat = 2; end
                2'd1: shadow[idx] = wd;
                2'd2: begin
                    exp_data = shadow[idx]; exp_lat = 2;
                    m_valid = 1'b1; m_word = ea[31:2];
                end
                default: begin
                    hit = m_valid && !clr && (m_word == ea[31:2]);
                    if (hit) shadow[idx] = wd;
                    exp_data = hit ? 32'd0 : 32'd1;
                    m_valid = 1'b0;
                end
            endcase
        end
        if (clr) m_valid = 1'b0;

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_is_write = wr;
        req_base = base; req_offset = off; req_wdata = wd; rsv_clear = clr;
        @(posedge clk);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 1) begin req_valid = 1'b0; rsv_clear = 1'b0; end
        end while (!rsp_valid && lat < 8);
        check({tag, " R11 latency"}, 32'(lat), 32'(exp_lat));
        check({tag, " data"}, rsp_data, exp_data);
        check({tag, " R9 err"}, {31'd0, rsp_err}, {31'd0, mis});
        check({tag, " R9 cause"}, {28'd0, rsp_cause}, {28'd0, exp_cause});
        check({tag, " mem word"}, bmem[idx], shadow[idx]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] a;
        for (int i = 0; i < 64; i++) begin
            bmem[i] = 32'hA500_0000 + 32'(i) * 32'h0101;
            shadow[i] = bmem[i];
        end
        repeat (3) @(negedge clk);
        check("R1 ready", {31'd0, req_ready}, 32'd1);
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 mem_en", {31'd0, mem_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", {31'd0, req_ready}, 32'd1);

        do_req("R1 sc after reset", 2'd3, 1'b1, REGION, 12'd0, 32'd101, 1'b0);
        do_req("R6 store", 2'd1, 1'b1, REGION + 4, 12'd0, 32'd105, 1'b0);
        do_req("R6 sc after store", 2'd3, 1'b1, REGION + 4, 12'd0, 32'd104, 1'b0);
        do_req("R4 sc retry", 2'd3, 1'b1, REGION + 4, 12'd0, 32'd104, 1'b0);
        do_req("R2 plain load no rsv", 2'd0, 1'b0, REGION + 4, 12'd0, 32'd0, 1'b0);
        do_req("R2 sc after plain load", 2'd3, 1'b1, REGION + 4, 12'd0, 32'd9, 1'b0);
        do_req("R2 lr", 2'd2, 1'b0, REGION + 8, 12'd0, 32'd0, 1'b0);
        do_req("R3 sc pass", 2'd3, 1'b1, REGION + 8, 12'd0, 32'd106, 1'b0);
        do_req("R5 second sc", 2'd3, 1'b1, REGION + 8, 12'd0, 32'd77, 1'b0);
        do_req("R7 lr ignores offset", 2'd2, 1'b0, REGION + 12, 12'd8, 32'd0, 1'b0);
        do_req("R7 sc ignores offset", 2'd3, 1'b1, REGION + 12, 12'hFFC, 32'd55, 1'b0);
        do_req("R7 load with neg offset", 2'd0, 1'b0, REGION + 20, 12'hFF8, 32'd0, 1'b0);
        do_req("R7 store with offset", 2'd1, 1'b1, REGION + 16, 12'd8, 32'd66, 1'b0);
        do_req("R8 lr word A", 2'd2, 1'b0, REGION + 16, 12'd0, 32'd0, 1'b0);
        do_req("R8 sc word B", 2'd3, 1'b1, REGION + 20, 12'd0, 32'd88, 1'b0);
        do_req("R8 sc word A after", 2'd3, 1'b1, REGION + 16, 12'd0, 32'd89, 1'b0);
        do_req("R9 lr", 2'd2, 1'b0, REGION + 24, 12'd0, 32'd0, 1'b0);
        do_req("R9 misaligned load", 2'd0, 1'b0, REGION, 12'd1, 32'd0, 1'b0);
        do_req("R9 misaligned store", 2'd1, 1'b1, REGION, 12'd2, 32'd3, 1'b0);
        do_req("R9 misaligned sc", 2'd3, 1'b1, REGION + 25, 12'd0, 32'd3, 1'b0);
        do_req("R9 misaligned lr", 2'd2, 1'b0, REGION + 27, 12'd0, 32'd0, 1'b0);
        do_req("R9 rsv survives fault", 2'd3, 1'b1, REGION + 24, 12'd0, 32'd123, 1'b0);
        do_req("R10 lr", 2'd2, 1'b0, REGION + 28, 12'd0, 32'd0, 1'b0);
        pulse_clear();
        do_req("R10 sc after clear", 2'd3, 1'b1, REGION + 28, 12'd0, 32'd5, 1'b0);
        do_req("R10 lr with clear", 2'd2, 1'b0, REGION + 28, 12'd0, 32'd0, 1'b1);
        do_req("R10 sc after lr+clear", 2'd3, 1'b1, REGION + 28, 12'd0, 32'd6, 1'b0);
        do_req("R10 lr", 2'd2, 1'b0, REGION + 32, 12'd0, 32'd0, 1'b0);
        do_req("R10 sc with clear", 2'd3, 1'b1, REGION + 32, 12'd0, 32'd7, 1'b1);

        void'($urandom(32'd4242));
        for (int k = 0; k < 400; k++) begin
            logic [1:0]  op;
            logic [11:0] off;
            logic [31:0] base;
            logic        clr;
            op  = 2'($urandom_range(0, 3));
            a   = REGION + 32'($urandom_range(0, 3)) * 4;
            if ($urandom_range(0, 9) == 0) a = a + 32'($urandom_range(1, 3));
            off = op[1] ? 12'($urandom_range(0, 4095)) : 12'($signed($urandom_range(0, 32)) - 16);
            base = op[1] ? a : a - {{20{off[11]}}, off};
            clr = ($urandom_range(0, 11) == 0);
            do_req("random", op, (op == 2'd1 || op == 2'd3), base, off,
                   $urandom, clr);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule